// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches a port of eight pins and records, for each pin, whether a chosen signal edge has occurred. Per pin, software picks the active edge (rising or falling), decides whether that pin may raise an interrupt, and reads a sticky event flag. The flag records the event even while the interrupt for that pin is masked. The enable bit only gates the request line, so software can poll masked pins.

Pin levels come from the pad, so an edge is caught whether the pin is an input or is being driven by the chip as an output. Each pin passes through a two-stage synchronizer before edge detection. Software reaches the polarity, enable and flag registers over a simple synchronous register bus. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high. Flags are cleared by writing ones. A parameter builds a reduced variant in which only the low flag bits exist.

Top module: `pei_ctrl`

## Requirements
- R1: After reset the polarity register (address 0), the enable register (address 1) and the flag register (address 2) read 0x00, and `irq_o` is 0.
- R2: A level change applied to a pin before a clock edge is seen by two synchronizer stages. The resulting flag bit reads 1 after the third rising clock edge and still reads 0 after the second.
- R3: Polarity bit value 1 selects the rising edge and value 0 selects the falling edge. An edge of the other direction does not set the flag.
- R4: A flag bit sets on its active edge even while its enable bit is 0.
- R5: Changing a polarity bit while the pin level is steady does not set that pin's flag.
- R6: A write to address 2 clears each flag bit written as 1 and leaves every flag bit written as 0 unchanged.
- R7: If an active edge sets a flag in the same cycle that a write of 1 clears it, the flag ends up 1.
- R8: `irq_o` is the OR over all pins of (flag AND enable). It is registered, so it follows a change of flag or enable one clock edge later.
- R9: With FLAG_BITS=4, flag bits 7..4 always read 0 and never contribute to `irq_o`. The polarity and enable registers remain eight bits wide.
- R10: Addresses 0 and 1 read back the last value written to them, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Pad levels of the port pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 polarity, 1 enable, 2 flags, 3 reserved |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the synchronizer latency. A design with one stage too few or too many sets the flag a cycle early or late. It drives edges of the wrong direction and changes polarity over a steady high pin, where a design that compares levels instead of transitions would raise false flags. It lines up a fresh edge with a write-1-to-clear in the same cycle, which a clear-priority design would lose. It checks that zeros written to the flag register leave flags alone. It checks that the reduced variant keeps its upper flags and request silent when those pins toggle. A long random run against a bench model also catches an unregistered or wrongly gated request line.

// File: rtl/pei_pkg.sv
package pei_pkg;

  typedef enum logic [1:0] {
    REG_POL = 2'd0,
    REG_ENA = 2'd1,
    REG_FLG = 2'd2,
    REG_RSV = 2'd3
  } pei_reg_e;

  // True when the synchronized level has just moved to the active level.
  function automatic logic is_active_edge(input logic lvl, input logic prev, input logic rise_sel);
    logic rising;
    logic falling;
    rising  = lvl & ~prev;
    falling = ~lvl & prev;
    return rise_sel ? rising : falling;
  endfunction

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
  parameter int W         = 8,
  parameter int FLAG_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] flag_o
);

  function automatic logic [W-1:0] impl_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < FLAG_BITS);
    return m;
  endfunction

  localparam logic [W-1:0] MASK = impl_mask();

  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit_o[i] = pei_pkg::is_active_edge(lvl_i[i], prev_q[i], pol_i[i]);
  end

  // set has priority over write-one-to-clear
  assign flag_d = (hit_o | (flag_q & ~clr_i)) & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R2, R3, R4: every implemented hit shows up in the flag one edge later
  a_r2_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_o & MASK)) |=> ((flag_o & $past(hit_o & MASK)) == $past(hit_o & MASK)));

  // R5: a flag may only rise after a real edge
  a_r5_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(hit_o)) == '0));

  // R6: a clear without a competing edge empties the bit
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~hit_o)) |=> ((flag_o & $past(clr_i & ~hit_o)) == '0));

  // R7: a colliding set and clear leaves the bit set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & hit_o & MASK)) |=> ((flag_o & $past(clr_i & hit_o & MASK)) != '0));

endmodule

// File: rtl/pei_regs.sv
module pei_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] ena_o,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] rdata_o
);

  import pei_pkg::*;

  pei_reg_e     sel;
  logic [W-1:0] pol_q;
  logic [W-1:0] ena_q;

  assign sel = pei_reg_e'(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ena_q <= '0;
    end else if (wr_i) begin
      if (sel == REG_POL) pol_q <= wdata_i;
      if (sel == REG_ENA) ena_q <= wdata_i;
    end
  end

  assign clr_o = (wr_i && sel == REG_FLG) ? wdata_i : '0;

  always_comb begin
    case (sel)
      REG_POL: rdata_o = pol_q;
      REG_ENA: rdata_o = ena_q;
      REG_FLG: rdata_o = flag_i;
      default: rdata_o = '0;
    endcase
  end

  assign pol_o = pol_q;
  assign ena_o = ena_q;

  // R10: a polarity write is visible from the next cycle
  a_r10_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0) |=> (pol_o == $past(wdata_i)));

  // R10: an enable write is visible from the next cycle
  a_r10_ena_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd1) |=> (ena_o == $past(wdata_i)));

  // R10: the reserved address returns zero
  a_r10_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd3) |-> (rdata_o == '0));

endmodule

// File: rtl/pei_irq.sv
module pei_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] ena_i,
  output logic         irq_o
);

  logic [W-1:0] live;
  logic         irq_q;

  assign live = flag_i & ena_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end

  assign irq_o = irq_q;

  // R8: nothing enabled and pending means no request next cycle
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_i & ena_i) == '0) |=> !irq_o);

  // R8: an enabled pending flag raises the request next cycle
  a_r8_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_i & ena_i) != '0) |=> irq_o);

endmodule

// File: rtl/pei_ctrl.sv
module pei_ctrl #(
  parameter int PINS        = 8,
  parameter int FLAG_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [PINS-1:0] bus_wdata_i,
  output logic [PINS-1:0] bus_rdata_o,
  output logic            irq_o
);

  logic [PINS-1:0] lvl;
  logic [PINS-1:0] pol;
  logic [PINS-1:0] ena;
  logic [PINS-1:0] clr;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] flag;

  pei_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (lvl)
  );

  pei_regs #(.W(PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .flag_i  (flag),
    .pol_o   (pol),
    .ena_o   (ena),
    .clr_o   (clr),
    .rdata_o (bus_rdata_o)
  );

  pei_edge #(.W(PINS), .FLAG_BITS(FLAG_BITS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .pol_i  (pol),
    .clr_i  (clr),
    .hit_o  (hit),
    .flag_o (flag)
  );

  pei_irq #(.W(PINS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (flag),
    .ena_i  (ena),
    .irq_o  (irq_o)
  );

  // R1: right after reset release nothing is pending
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag == '0 && !irq_o));

endmodule

// File: tb/pei_ctrl_tb.sv
`timescale 1ns/1ps
module pei_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_lo;
  logic       irq, irq_lo;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done = 1'b0;

  // bench model state
  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [7:0] m_flag = '0, m_pol = '0, m_ena = '0;
  logic       m_irq = 1'b0, m_irq_lo = 1'b0;

  always #10 clk = ~clk;

  pei_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  pei_ctrl #(.FLAG_BITS(4)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_lo), .irq_o(irq_lo)
  );

  // an edge counts when the level moved and now equals the polarity bit
  function automatic logic [7:0] f_hit(input logic [7:0] now, input logic [7:0] old, input logic [7:0] pol);
    return (now ^ old) & ~(now ^ pol);
  endfunction

  function automatic logic [7:0] f_read(input logic [1:0] a, input logic [7:0] fl);
    case (a)
      2'd0:    return m_pol;
      2'd1:    return m_ena;
      2'd2:    return fl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // one clock edge; model advances from the values driven now
  task automatic tick();
    logic [7:0] clr, nflag;
    clr   = (wr && addr == 2'd2) ? wdata : 8'h00;
    nflag = f_hit(m_s2, m_prev, m_pol) | (m_flag & ~clr);
    @(posedge clk);
    m_irq    = |(m_flag & m_ena);
    m_irq_lo = |(m_flag & 8'h0F & m_ena);
    m_prev   = m_s2;
    m_s2     = m_s1;
    m_s1     = pins;
    if (wr && addr == 2'd0) m_pol = wdata;
    if (wr && addr == 2'd1) m_ena = wdata;
    m_flag   = nflag;
    @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0]);
      chk("R1 reset read", rdata, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R10 register readback
    wreg(2'd0, 8'hA5); peek(2'd0); chk("R10 pol readback", rdata, 8'hA5);
    wreg(2'd1, 8'h3C); peek(2'd1); chk("R10 ena readback", rdata, 8'h3C);
    peek(2'd3); chk("R10 reserved zero", rdata, 8'h00);
    wreg(2'd0, 8'h01);
    wreg(2'd1, 8'h00);

    // R2 latency, R3 rising, R4 set while masked
    pins = 8'h01;
    ticks(2); peek(2'd2); chk("R2 not yet after two edges", rdata, 8'h00);
    tick();   peek(2'd2); chk("R2 R4 flag after third edge", rdata, 8'h01);
    tick();   chk("R4 masked irq", {7'd0, irq}, 8'h00);

    // R8 registered request
    wreg(2'd1, 8'h01); chk("R8 irq one edge late", {7'd0, irq}, 8'h00);
    tick();            chk("R8 irq raised", {7'd0, irq}, 8'h01);

    // R6 write one to clear
    wreg(2'd2, 8'h00); peek(2'd2); chk("R6 zero keeps", rdata, 8'h01);
    wreg(2'd2, 8'hFE); peek(2'd2); chk("R6 other bits keep", rdata, 8'h01);
    wreg(2'd2, 8'h01); peek(2'd2); chk("R6 one clears", rdata, 8'h00);
    chk("R8 irq still set", {7'd0, irq}, 8'h01);
    tick();            chk("R8 irq dropped", {7'd0, irq}, 8'h00);

    // R3 wrong direction ignored, falling polarity
    pins = 8'h00; ticks(4); peek(2'd2); chk("R3 fall ignored on rising pol", rdata, 8'h00);
    pins = 8'h02; ticks(4); peek(2'd2); chk("R3 rise ignored on falling pol", rdata, 8'h00);
    pins = 8'h00; ticks(3); peek(2'd2); chk("R3 falling sets", rdata, 8'h02);
    wreg(2'd2, 8'h02);

    // R5 polarity change over steady high pin
    pins = 8'h02; ticks(4);
    wreg(2'd0, 8'h03); ticks(3); peek(2'd2); chk("R5 pol change no flag", rdata, 8'h00);

    // R7 set beats clear
    wreg(2'd0, 8'h07);
    pins = 8'h06; ticks(3); peek(2'd2); chk("R7 setup flag", rdata, 8'h04);
    pins = 8'h02; ticks(3);
    pins = 8'h06; ticks(2);
    wreg(2'd2, 8'h04); peek(2'd2); chk("R7 set wins", rdata, 8'h04);
    wreg(2'd2, 8'h04); peek(2'd2); chk("R7 later clear", rdata, 8'h00);

    // R9 reduced variant
    wreg(2'd0, 8'hF0);
    pins = 8'hF6; ticks(3); peek(2'd2);
    chk("R9 full variant upper flags", rdata, 8'hF0);
    chk("R9 reduced upper flags zero", rdata_lo, 8'h00);
    wreg(2'd1, 8'hF0); tick();
    chk("R9 full irq", {7'd0, irq}, 8'h01);
    chk("R9 reduced irq quiet", {7'd0, irq_lo}, 8'h00);
    peek(2'd1); chk("R9 reduced enable full width", rdata_lo, 8'hF0);
    wreg(2'd2, 8'hFF);

    // random run against the bench model (R2, R3, R6, R7, R8, R10)
    for (int n = 0; n < 3000; n++) begin
      peek(2'($urandom_range(0, 3)));
      chk("R10 R6 random read", rdata, f_read(addr, m_flag));
      chk("R9 random reduced read", rdata_lo, f_read(addr, m_flag & 8'h0F));
      chk("R8 random irq", {7'd0, irq}, {7'd0, m_irq});
      chk("R8 R9 random reduced irq", {7'd0, irq_lo}, {7'd0, m_irq_lo});
      if ($urandom_range(0, 2) == 0) pins = pins ^ 8'($urandom());
      wr    = ($urandom_range(0, 3) == 0);
      addr  = 2'($urandom_range(0, 3));
      wdata = 8'($urandom());
      tick();
      wr = 1'b0;
    end

    finish_run();
  end

endmodule